// File: doc/BRIEF.md
# Ethernet Receive Address Filter

This block decides whether an incoming Ethernet frame is kept or discarded, looking only at the first sixteen bytes of the frame. The frame header arrives one byte per beat on a valid/ready stream. The block combines a set of receive control bits, a configured VLAN ethertype and three tables to reach its verdict. The tables are sixteen exact-match station addresses, a 4096-bit multicast hash table and a 4096-bit VLAN ID table, and all three are loaded through a simple write port. Exactly one verdict is produced per frame. It appears as a single-cycle strobe with an accept bit, one cycle after the beat that completes the header.

The checks run in a fixed priority order. VLAN rejection comes first. Then come promiscuous unicast, promiscuous multicast and broadcast. Then the exact-match entries are searched, and last of all the multicast hash lookup is made. A frame that ends before sixteen bytes is treated as though the missing bytes were zero. Beats after the sixteenth byte are consumed and ignored until the beat flagged as last.

Back-pressure: `in_ready` is low during reset and high at every cycle after it, so the block never stalls the stream. A beat is taken only in a cycle where `in_valid` and `in_ready` are both high. Gaps with `in_valid` low are allowed anywhere in a frame. The verdict strobe has no ready and cannot be held off.

Top module: `rx_addr_filter`

## Requirements
- R1: Reset clears every table entry (all exact entries invalid, all hash and VLAN bits zero) and holds `dec_valid` low. After reset, a unicast frame with all control bits clear is dropped.
- R2: When VLAN filtering is enabled (`rx_ctl[3]`) and bytes 12..13, read as a big-endian word, equal `vlan_type`, the VLAN ID is {byte14[3:0], byte15}. The frame is then dropped if bit ID[4:0] of VLAN table word ID[11:5] is clear, whatever the other checks would decide.
- R3: A frame that passes the VLAN check is accepted when promiscuous unicast (`rx_ctl[0]`) is set.
- R4: A frame is accepted when bit 0 of destination byte 0 is set and promiscuous multicast (`rx_ctl[1]`) is set.
- R5: A frame is accepted when broadcast accept (`rx_ctl[2]`) is set and destination bytes 0..5 are all 0xFF.
- R6: Exact entry e uses table word 2e as its low word and 2e+1 as its high word (`tbl_sel`=0). The entry takes part only when bit 31 of its high word is set. It matches when destination bytes 0..3 equal low-word bits [7:0],[15:8],[23:16],[31:24] and bytes 4..5 equal high-word bits [7:0],[15:8].
- R7: The hash index is {byte5, byte4} shifted right by 4, 3, 2 or 0 for `rx_ctl[13:12]` = 0, 1, 2 or 3, keeping 12 bits. The frame is accepted when bit index[4:0] of hash word index[11:5] (`tbl_sel`=1) is set, and dropped otherwise. VLAN table words use `tbl_sel`=2.
- R8: A frame whose last beat comes before byte 15 is filtered as if all its missing header bytes were zero.
- R9: `dec_valid` pulses exactly once per frame, in the cycle after the beat carrying byte 15 or the last beat, whichever comes first. Beats after byte 15 up to the last beat produce no verdict.
- R10: `in_ready` is low during reset and high in every cycle afterwards. Beats with `in_valid` low are not consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Header byte beat is valid |
| in_ready | output | 1 | Block can take a beat |
| in_data | input | 8 | Frame byte, destination byte 0 first |
| in_last | input | 1 | Beat is the final byte of the frame |
| rx_ctl | input | 16 | Receive control: bit0 unicast promiscuous, bit1 multicast promiscuous, bit2 broadcast accept, bit3 VLAN filter enable, bits 13:12 hash window |
| vlan_type | input | 16 | Ethertype that marks a VLAN tagged frame |
| tbl_we | input | 1 | Table write strobe |
| tbl_sel | input | 2 | Table select: 0 exact, 1 hash, 2 VLAN |
| tbl_addr | input | 7 | Table word address |
| tbl_wdata | input | 32 | Table write data |
| dec_valid | output | 1 | Verdict strobe |
| dec_accept | output | 1 | Verdict: 1 accept, 0 drop |

## Verification
The assertions take for granted that `rx_ctl`, `vlan_type` and the tables hold still during the beat that completes a header. The verdict is formed from their values in that cycle. The stimulus writes tables and changes control only while no frame is in flight, between frames. All stimulus obeys the stream rule: a beat counts only when `in_valid` is high. Frames are sent with and without idle gaps, as single-byte frames back to back, and with lengths on both sides of sixteen bytes.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  localparam int BYTE_W = 8;

  // receive control bit positions
  localparam int CTL_UC_PROMISC = 0;
  localparam int CTL_MC_PROMISC = 1;
  localparam int CTL_BCAST      = 2;
  localparam int CTL_VLAN_FILT  = 3;
  localparam int CTL_WIN_LO     = 12;

  // byte positions within the header
  localparam int POS_ETYPE = 12;
  localparam int POS_TCI   = 14;

  typedef enum logic [1:0] {
    TBL_EXACT = 2'd0,
    TBL_HASH  = 2'd1,
    TBL_VLAN  = 2'd2
  } tbl_sel_e;

  typedef struct packed {
    logic tagged_frame;
    logic vlan_reject;
    logic uc_promisc;
    logic mc_promisc;
    logic bcast;
    logic exact_hit;
    logic hash_hit;
  } verdict_t;

endpackage

// File: rtl/rxf_hdr_capture.sv
module rxf_hdr_capture #(
  parameter int HDR_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [7:0]             in_data,
  input  logic                   in_last,
  output logic [HDR_BYTES*8-1:0] hdr_o,
  output logic                   eval_o
);
  localparam int CNT_W = $clog2(HDR_BYTES + 1);
  localparam int HDR_W = HDR_BYTES * 8;

  logic             ready_q;
  logic             skip_q;
  logic [CNT_W-1:0] cnt_q;
  logic [HDR_W-1:0] hdr_q;
  logic             beat;
  logic             at_end;

  assign in_ready = ready_q;
  assign beat     = in_valid && ready_q;
  assign at_end   = in_last || (cnt_q == CNT_W'(HDR_BYTES - 1));
  assign eval_o   = beat && !skip_q && at_end;

  // header view: captured bytes, the byte on the bus, zeros after it
  always_comb begin
    for (int i = 0; i < HDR_BYTES; i++) begin
      if (CNT_W'(i) < cnt_q)
        hdr_o[i*8 +: 8] = hdr_q[i*8 +: 8];
      else if (CNT_W'(i) == cnt_q)
        hdr_o[i*8 +: 8] = in_data;
      else
        hdr_o[i*8 +: 8] = 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ready_q <= 1'b0;
      skip_q  <= 1'b0;
      cnt_q   <= '0;
      hdr_q   <= '0;
    end else begin
      ready_q <= 1'b1;
      if (beat) begin
        if (skip_q) begin
          if (in_last) skip_q <= 1'b0;
        end else begin
          hdr_q <= hdr_o;
          if (at_end) begin
            cnt_q  <= '0;
            skip_q <= !in_last;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(HDR_BYTES));

  p_skip_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_q && beat && !in_last) |=> skip_q);

  p_ready_after_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> in_ready);

endmodule

// File: rtl/rxf_tables.sv
module rxf_tables
  import rxf_pkg::*;
#(
  parameter int N_EXACT = 16,
  parameter int IDX_W   = 12,
  parameter int WORD_W  = 32,
  parameter int ADDR_W  = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [47:0]       dest,
  input  logic [IDX_W-1:0]  hash_idx,
  input  logic [IDX_W-1:0]  vid,
  output logic              exact_hit,
  output logic              hash_bit,
  output logic              vlan_bit
);
  localparam int BIT_W     = $clog2(WORD_W);
  localparam int TBL_WORDS = (1 << IDX_W) / WORD_W;
  localparam int EX_W      = $clog2(N_EXACT);
  localparam int VALID_BIT = WORD_W - 1;

  logic [WORD_W-1:0] hash_q [TBL_WORDS];
  logic [WORD_W-1:0] vlan_q [TBL_WORDS];
  logic [WORD_W-1:0] lo_q   [N_EXACT];
  logic [WORD_W-1:0] hi_q   [N_EXACT];
  logic [N_EXACT-1:0] hit_vec;
  logic [EX_W-1:0]    ex_idx;

  assign ex_idx = wr_addr[EX_W:1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int w = 0; w < TBL_WORDS; w++) begin
        hash_q[w] <= '0;
        vlan_q[w] <= '0;
      end
      for (int e = 0; e < N_EXACT; e++) begin
        lo_q[e] <= '0;
        hi_q[e] <= '0;
      end
    end else if (wr_en) begin
      case (tbl_sel_e'(wr_sel))
        TBL_EXACT: begin
          if (wr_addr[0]) hi_q[ex_idx] <= wr_data;
          else            lo_q[ex_idx] <= wr_data;
        end
        TBL_HASH: hash_q[wr_addr] <= wr_data;
        TBL_VLAN: vlan_q[wr_addr] <= wr_data;
        default: ;
      endcase
    end
  end

  for (genvar e = 0; e < N_EXACT; e++) begin : g_exact
    assign hit_vec[e] = hi_q[e][VALID_BIT] && (dest == {hi_q[e][15:0], lo_q[e]});
  end

  assign exact_hit = |hit_vec;
  assign hash_bit  = hash_q[hash_idx[IDX_W-1:BIT_W]][hash_idx[BIT_W-1:0]];
  assign vlan_bit  = vlan_q[vid[IDX_W-1:BIT_W]][vid[BIT_W-1:0]];

  p_exact_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_sel == TBL_EXACT && wr_addr[0]) |=>
      hi_q[$past(ex_idx)] == $past(wr_data));

endmodule

// File: rtl/rxf_decide.sv
module rxf_decide
  import rxf_pkg::*;
#(
  parameter int HDR_BYTES = 16,
  parameter int IDX_W     = 12
) (
  input  logic [HDR_BYTES*8-1:0] hdr,
  input  logic [15:0]            rx_ctl,
  input  logic [15:0]            vlan_type,
  input  logic                   exact_hit,
  input  logic                   hash_bit,
  input  logic                   vlan_bit,
  output logic [47:0]            dest,
  output logic [IDX_W-1:0]       hash_idx,
  output logic [IDX_W-1:0]       vid,
  output verdict_t               verdict,
  output logic                   accept
);
  logic [7:0]  byte0;
  logic [15:0] etype;
  logic [15:0] tci;
  logic [15:0] hkey;
  logic [15:0] hshift;

  assign dest  = hdr[47:0];
  assign byte0 = hdr[7:0];
  assign etype = {hdr[POS_ETYPE*8 +: 8], hdr[(POS_ETYPE+1)*8 +: 8]};
  assign tci   = {hdr[POS_TCI*8 +: 8], hdr[(POS_TCI+1)*8 +: 8]};
  assign vid   = tci[IDX_W-1:0];
  assign hkey  = {hdr[5*8 +: 8], hdr[4*8 +: 8]};

  always_comb begin
    case (rx_ctl[CTL_WIN_LO +: 2])
      2'd0:    hshift = hkey >> 4;
      2'd1:    hshift = hkey >> 3;
      2'd2:    hshift = hkey >> 2;
      default: hshift = hkey;
    endcase
  end

  assign hash_idx = hshift[IDX_W-1:0];

  always_comb begin
    verdict.tagged_frame = (etype == vlan_type);
    verdict.vlan_reject  = rx_ctl[CTL_VLAN_FILT] && verdict.tagged_frame && !vlan_bit;
    verdict.uc_promisc   = rx_ctl[CTL_UC_PROMISC];
    verdict.mc_promisc   = rx_ctl[CTL_MC_PROMISC] && byte0[0];
    verdict.bcast        = rx_ctl[CTL_BCAST] && (dest == 48'hFFFF_FFFF_FFFF);
    verdict.exact_hit    = exact_hit;
    verdict.hash_hit     = hash_bit;
  end

  assign accept = !verdict.vlan_reject &&
                  (verdict.uc_promisc || verdict.mc_promisc || verdict.bcast ||
                   verdict.exact_hit  || verdict.hash_hit);

endmodule

// File: rtl/rx_addr_filter.sv
module rx_addr_filter
  import rxf_pkg::*;
#(
  parameter int HDR_BYTES = 16,
  parameter int N_EXACT   = 16,
  parameter int IDX_W     = 12,
  parameter int WORD_W    = 32,
  parameter int ADDR_W    = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic [15:0]       rx_ctl,
  input  logic [15:0]       vlan_type,
  input  logic              tbl_we,
  input  logic [1:0]        tbl_sel,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [WORD_W-1:0] tbl_wdata,
  output logic              dec_valid,
  output logic              dec_accept
);
  localparam int HDR_W = HDR_BYTES * 8;

  logic [HDR_W-1:0] hdr;
  logic             eval;
  logic [47:0]      dest;
  logic [IDX_W-1:0] hash_idx;
  logic [IDX_W-1:0] vid;
  logic             exact_hit;
  logic             hash_bit;
  logic             vlan_bit;
  logic             accept;
  verdict_t         verdict;
  logic             dec_valid_q;
  logic             dec_accept_q;

  rxf_hdr_capture #(.HDR_BYTES(HDR_BYTES)) u_capture (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (in_data),
    .in_last  (in_last),
    .hdr_o    (hdr),
    .eval_o   (eval)
  );

  rxf_decide #(.HDR_BYTES(HDR_BYTES), .IDX_W(IDX_W)) u_decide (
    .hdr       (hdr),
    .rx_ctl    (rx_ctl),
    .vlan_type (vlan_type),
    .exact_hit (exact_hit),
    .hash_bit  (hash_bit),
    .vlan_bit  (vlan_bit),
    .dest      (dest),
    .hash_idx  (hash_idx),
    .vid       (vid),
    .verdict   (verdict),
    .accept    (accept)
  );

  rxf_tables #(
    .N_EXACT (N_EXACT),
    .IDX_W   (IDX_W),
    .WORD_W  (WORD_W),
    .ADDR_W  (ADDR_W)
  ) u_tables (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tbl_we),
    .wr_sel    (tbl_sel),
    .wr_addr   (tbl_addr),
    .wr_data   (tbl_wdata),
    .dest      (dest),
    .hash_idx  (hash_idx),
    .vid       (vid),
    .exact_hit (exact_hit),
    .hash_bit  (hash_bit),
    .vlan_bit  (vlan_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dec_valid_q  <= 1'b0;
      dec_accept_q <= 1'b0;
    end else begin
      dec_valid_q <= eval;
      if (eval) dec_accept_q <= accept;
    end
  end

  assign dec_valid  = dec_valid_q;
  assign dec_accept = dec_accept_q;

  p_vlan_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && verdict.vlan_reject) |=> (dec_valid && !dec_accept));

  p_bcast_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (eval && verdict.bcast && !verdict.vlan_reject) |=> dec_accept);

  p_strobe_follows_beat_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> $past(in_valid && in_ready));

  p_no_verdict_in_reset_r1: assert property (@(posedge clk)
    !rst_n |=> !dec_valid);

endmodule

// File: tb/rx_addr_filter_bench.sv
module rx_addr_filter_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_data = 8'h00;
  logic        in_last = 1'b0;
  logic [15:0] rx_ctl = 16'h0000;
  logic [15:0] vlan_type = 16'h8100;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_sel = 2'd0;
  logic [6:0]  tbl_addr = 7'd0;
  logic [31:0] tbl_wdata = 32'd0;
  logic        dec_valid;
  logic        dec_accept;

  always #5 clk = ~clk;

  rx_addr_filter u_rx_addr_filter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .rx_ctl(rx_ctl), .vlan_type(vlan_type),
    .tbl_we(tbl_we), .tbl_sel(tbl_sel), .tbl_addr(tbl_addr), .tbl_wdata(tbl_wdata),
    .dec_valid(dec_valid), .dec_accept(dec_accept)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    finished = 1'b0;
  bit    exp_valid = 1'b0;
  bit    exp_acc = 1'b0;
  string cur_tag = "R1";

  // bench copies of the tables
  logic [31:0] m_hash [128];
  logic [31:0] m_vlan [128];
  logic [31:0] m_lo [16];
  logic [31:0] m_hi [16];
  logic [7:0]  fq [$];

  task automatic check(input string tag, input int act, input int exp, input string what);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // every cycle: strobe timing and verdict
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R9", int'(dec_valid), int'(exp_valid), "dec_valid timing");
      if (exp_valid) check(cur_tag, int'(dec_accept), int'(exp_acc), "verdict");
    end
  end

  task automatic tick(input bit dv, input bit acc);
    @(posedge clk);
    #1;
    exp_valid = dv;
    exp_acc   = acc;
  endtask

  function automatic bit model(input logic [127:0] hv);
    int vid, key, f, sh;
    logic [7:0] b [16];
    for (int i = 0; i < 16; i++) b[i] = hv[i*8 +: 8];
    if (rx_ctl[3] && ({b[12], b[13]} == vlan_type)) begin
      vid = (int'(b[14] & 8'h0F) << 8) | int'(b[15]);
      if (m_vlan[vid / 32][vid % 32] == 1'b0) return 1'b0;
    end
    if (rx_ctl[0]) return 1'b1;
    if (b[0][0] && rx_ctl[1]) return 1'b1;
    if (rx_ctl[2] && b[0] == 8'hFF && b[1] == 8'hFF && b[2] == 8'hFF &&
        b[3] == 8'hFF && b[4] == 8'hFF && b[5] == 8'hFF) return 1'b1;
    for (int e = 0; e < 16; e++) begin
      if (m_hi[e][31] && b[0] == m_lo[e][7:0] && b[1] == m_lo[e][15:8] &&
          b[2] == m_lo[e][23:16] && b[3] == m_lo[e][31:24] &&
          b[4] == m_hi[e][7:0] && b[5] == m_hi[e][15:8]) return 1'b1;
    end
    case (rx_ctl[13:12])
      2'd0: sh = 4;
      2'd1: sh = 3;
      2'd2: sh = 2;
      default: sh = 0;
    endcase
    key = (int'(b[5]) << 8) | int'(b[4]);
    f = (key >> sh) & 12'hFFF;
    return m_hash[f / 32][f % 32];
  endfunction

  task automatic wr(input int sel, input int addr, input logic [31:0] data);
    tbl_we = 1'b1; tbl_sel = 2'(sel); tbl_addr = 7'(addr); tbl_wdata = data;
    case (sel)
      0: if (addr % 2 == 1) m_hi[addr / 2] = data; else m_lo[addr / 2] = data;
      1: m_hash[addr] = data;
      default: m_vlan[addr] = data;
    endcase
    tick(1'b0, 1'b0);
    tbl_we = 1'b0;
  endtask

  // frame builder: destination little-endian, ethertype, tag control, filler
  task automatic build(input logic [47:0] dst, input logic [15:0] et,
                       input logic [15:0] tci, input int len);
    fq = {};
    for (int k = 0; k < 6; k++) fq.push_back(dst[k*8 +: 8]);
    for (int k = 0; k < 6; k++) fq.push_back(8'h20 + 8'(k));
    fq.push_back(et[15:8]); fq.push_back(et[7:0]);
    fq.push_back(tci[15:8]); fq.push_back(tci[7:0]);
    while (fq.size() < len) fq.push_back(8'(fq.size() * 7));
    while (fq.size() > len) void'(fq.pop_back());
  endtask

  task automatic send(input string tag, input bit gaps);
    logic [127:0] hv;
    int dec_at;
    bit acc;
    hv = '0;
    for (int k = 0; k < 16; k++) if (k < fq.size()) hv[k*8 +: 8] = fq[k];
    dec_at = (fq.size() < 16) ? fq.size() - 1 : 15;
    acc = model(hv);
    for (int k = 0; k < fq.size(); k++) begin
      if (gaps && (k % 3 == 1)) begin
        in_valid = 1'b0;
        tick(1'b0, 1'b0);
      end
      in_valid = 1'b1; in_data = fq[k]; in_last = (k == fq.size() - 1);
      if (k == dec_at) cur_tag = tag;
      tick(k == dec_at, acc);
    end
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  initial begin
    for (int i = 0; i < 128; i++) begin m_hash[i] = '0; m_vlan[i] = '0; end
    for (int i = 0; i < 16; i++) begin m_lo[i] = '0; m_hi[i] = '0; end
    // R1 / R10: reset state
    repeat (3) tick(1'b0, 1'b0);
    check("R1", int'(dec_valid), 0, "dec_valid in reset");
    check("R10", int'(in_ready), 0, "in_ready in reset");
    rst_n = 1'b1;
    tick(1'b0, 1'b0);
    check("R10", int'(in_ready), 1, "in_ready after reset");

    // R1: empty tables, no control bits -> drop
    build(48'h0000_5544_3322, 16'h0800, 16'h0, 20);
    send("R1", 1'b0);
    tick(1'b0, 1'b0);

    // R3: unicast promiscuous
    rx_ctl = 16'h0001;
    send("R3", 1'b1);

    // R4: multicast promiscuous
    rx_ctl = 16'h0002;
    build(48'h0000_0000_5E01, 16'h0800, 16'h0, 16);
    send("R4", 1'b0);
    build(48'h0000_0000_5E02, 16'h0800, 16'h0, 16);
    send("R4", 1'b0);

    // R5: broadcast
    rx_ctl = 16'h0004;
    build(48'hFFFF_FFFF_FFFF, 16'h0806, 16'h0, 18);
    send("R5", 1'b0);
    build(48'hFEFF_FFFF_FFFF, 16'h0806, 16'h0, 18);
    send("R5", 1'b0);

    // R6: exact entries, valid bit and byte order
    rx_ctl = 16'h0000;
    wr(0, 10, 32'h4433_2211);
    wr(0, 11, 32'h8000_6655);
    wr(0, 30, 32'hDDCC_BBAA);
    wr(0, 31, 32'h0000_FFEE);
    build(48'h6655_4433_2211, 16'h0800, 16'h0, 16);
    send("R6", 1'b0);
    build(48'h1122_3344_5566, 16'h0800, 16'h0, 16);
    send("R6", 1'b0);
    build(48'hFFEE_DDCC_BBAA, 16'h0800, 16'h0, 16);
    send("R6", 1'b1);
    wr(0, 31, 32'h8000_FFEE);
    send("R6", 1'b0);

    // R7: hash window for each offset setting
    wr(1, 7'h55, 32'h0001_0100);
    wr(1, 7'h2A, 32'h8000_0000);
    for (int off = 0; off < 4; off++) begin
      rx_ctl = 16'(off) << 12;
      build(48'hAB50_0000_0000, 16'h0800, 16'h0, 16);
      send("R7", 1'b0);
      build(48'h0AA8_0000_0000, 16'h0800, 16'h0, 16);
      send("R7", 1'b0);
      build(48'h0AA0_0000_0000, 16'h0800, 16'h0, 16);
      send("R7", 1'b0);
      build(48'h0557_C000_0000, 16'h0800, 16'h0, 16);
      send("R7", 1'b0);
    end

    // R2: VLAN rejection before promiscuous acceptance
    rx_ctl = 16'h0009;
    build(48'h0000_0000_0002, 16'h8100, 16'h0123, 20);
    send("R2", 1'b0);
    wr(2, 9, 32'h0000_0008);
    send("R2", 1'b0);
    build(48'h0000_0000_0002, 16'h8100, 16'hF124, 20);
    send("R2", 1'b1);
    rx_ctl = 16'h0001;
    send("R2", 1'b0);
    rx_ctl = 16'h0009;
    build(48'h0000_0000_0002, 16'h88A8, 16'h0124, 20);
    send("R2", 1'b0);

    // R8: short frames padded with zeros
    rx_ctl = 16'h0000;
    wr(0, 0, 32'h0000_0203);
    wr(0, 1, 32'h8000_0000);
    build(48'h0000_0000_0203, 16'h0, 16'h0, 2);
    send("R8", 1'b0);
    build(48'h0000_0000_0203, 16'h0, 16'h0, 1);
    send("R8", 1'b0);
    vlan_type = 16'h0000;
    rx_ctl = 16'h0009;
    build(48'h0000_0000_0001, 16'h0, 16'h0, 5);
    send("R8", 1'b0);
    wr(2, 0, 32'h0000_0001);
    send("R8", 1'b0);
    vlan_type = 16'h8100;

    // R9: back-to-back single-byte frames and long frames with gaps
    rx_ctl = 16'h0002;
    for (int k = 0; k < 4; k++) begin
      build(48'(k), 16'h0, 16'h0, 1);
      send("R9", 1'b0);
    end
    build(48'h0000_0000_0001, 16'h0800, 16'h0, 40);
    send("R9", 1'b1);
    build(48'h0000_0000_0002, 16'h0800, 16'h0, 17);
    send("R9", 1'b0);
    tick(1'b0, 1'b0);

    // mixed patterns against the model
    for (int w = 0; w < 128; w += 5) wr(1, w, $urandom);
    for (int w = 0; w < 128; w += 3) wr(2, w, $urandom);
    for (int n = 0; n < 150; n++) begin
      logic [47:0] d;
      int e;
      e = n % 16;
      rx_ctl = {2'b00, 2'($urandom), 8'h00, 1'b0, 3'($urandom & (n % 4 == 0 ? 7 : 6))} | 16'h0008;
      d = {$urandom, $urandom};
      if (n % 5 == 0) d = 48'hFFFF_FFFF_FFFF;
      if (n % 7 == 0) begin
        wr(0, 2 * e, d[31:0]);
        wr(0, 2 * e + 1, {1'b1, 15'h0, d[47:32]});
      end
      build(d, (n % 3 == 0) ? 16'h8100 : 16'h0800, 16'($urandom), 1 + (n * 7) % 30);
      send("R7", n[0]);
    end
    tick(1'b0, 1'b0);
    tick(1'b0, 1'b0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule